// File: doc/BRIEF.md
# Dual-Screen Picture Compositor

This block merges two RGB555 pictures, one from the bottom screen source and one from the top screen source, into a single stream for one 256x192 display. A pixel stream with a valid flag and x/y coordinates drives it. For each valid coordinate the block reads both sources through two read ports that return data one cycle later. It then produces the composed pixel, together with its valid flag, two cycles after the input.

A 2-bit window mode picks the layout. Mode 0 shows the main picture only. Mode 1 blends the two pictures over the whole frame in eighths. Modes 2 and 3 place a half-size copy of the sub picture in the lower-left or lower-right quarter of the frame, blended in quarters, and show the main picture elsewhere. A 2-bit blend select picks the weights. A swap bit decides which source is main and which is sub. All controls are sampled with each pixel.

Top module: `pic_compositor`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` delayed by exactly two clock cycles. The pixel that belongs to an input appears on `out_pix_o` in that same cycle.
- R2: In window mode 0, every output pixel equals the main pixel at (x, y).
- R3: In window mode 1, every channel is (wm·main + ws·sub) >> 3, with sub read at (x, y). Blend select 0,1,2,3 gives wm:ws = 7:1, 6:2, 5:3, 4:4.
- R4: In window mode 2 the inset covers x < 128 and y ≥ 96. Pixels outside it equal the main pixel unchanged.
- R5: In window mode 3 the inset covers x ≥ 128 and y ≥ 96. Pixels outside it equal the main pixel unchanged.
- R6: Inside the inset, every channel is (wm·main + ws·sub) >> 2. Blend select 0,1,2,3 gives wm:ws = 3:1, 2:2, 1:3, 0:4, so select 3 shows the sub pixel alone.
- R7: The main source is read at (x, y). Inside the inset, the sub source is read at (2·(x − x0), 2·(y − 96)), where x0 is 0 in mode 2 and 128 in mode 3. Addresses are presented in the cycle of the input, and data returns one cycle later.
- R8: With `swap_i` = 0 the bottom port is main and the top port is sub. With `swap_i` = 1 the roles are exchanged.
- R9: A pixel holds three 5-bit channels at bits [4:0], [9:5] and [14:10]. Each channel is blended on its own, and the result is truncated, not rounded.
- R10: While `rst_ni` is low, `out_valid_o` and `out_pix_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_mode_i | input | 2 | Window mode 0..3 |
| blend_sel_i | input | 2 | Blend weight select |
| swap_i | input | 1 | Exchange main and sub sources |
| in_valid_i | input | 1 | Input coordinate valid |
| x_i | input | 8 | Pixel column |
| y_i | input | 8 | Pixel row |
| bot_x_o | output | 8 | Bottom source read column |
| bot_y_o | output | 8 | Bottom source read row |
| bot_pix_i | input | 15 | Bottom source data, one cycle after address |
| top_x_o | output | 8 | Top source read column |
| top_y_o | output | 8 | Top source read row |
| top_pix_i | input | 15 | Top source data, one cycle after address |
| out_valid_o | output | 1 | Output pixel valid |
| out_pix_o | output | 15 | Composed RGB555 pixel |

## Verification
The hardest situations are at the inset edges: columns 127/128 and rows 95/96, with a mode, select and swap that change from one pixel to the next. Stale control or a one-off boundary compare shows up only there. The stimulus walks these edge coordinates in directed passes over every mode, select and swap value. It then mixes random coordinates, controls and valid gaps, so that consecutive pixels in flight carry different settings. The bench sources hold distinct content at every address, so a wrong read address or a source swap changes the output value.

// File: rtl/comp_pkg.sv
package comp_pkg;
  typedef enum logic [1:0] {
    WIN_MAIN    = 2'd0,
    WIN_FULL    = 2'd1,
    WIN_INSET_L = 2'd2,
    WIN_INSET_R = 2'd3
  } win_e;

  // weights are in eighths; quarter weights are doubled
  localparam int WT_W = 4;
  localparam int WT_SHIFT = 3;
endpackage

// File: rtl/comp_addr_gen.sv
module comp_addr_gen import comp_pkg::*; #(
  parameter int H_PIX = 256,
  parameter int V_PIX = 192,
  localparam int XW = $clog2(H_PIX),
  localparam int YW = $clog2(V_PIX)
) (
  input  logic [1:0]    win_mode_i,
  input  logic          swap_i,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  output logic [XW-1:0] bot_x_o,
  output logic [YW-1:0] bot_y_o,
  output logic [XW-1:0] top_x_o,
  output logic [YW-1:0] top_y_o,
  output logic          inset_o
);
  localparam logic [XW-1:0] X_HALF = XW'(H_PIX / 2);
  localparam logic [YW-1:0] Y_HALF = YW'(V_PIX / 2);

  win_e          mode;
  logic          in_low;
  logic [XW-1:0] x0, dx, sub_x;
  logic [YW-1:0] dy, sub_y;

  always_comb begin
    mode   = win_e'(win_mode_i);
    in_low = (y_i >= Y_HALF);
    unique case (mode)
      WIN_INSET_L: inset_o = in_low && (x_i < X_HALF);
      WIN_INSET_R: inset_o = in_low && (x_i >= X_HALF);
      default:     inset_o = 1'b0;
    endcase
    x0    = (mode == WIN_INSET_R) ? X_HALF : '0;
    dx    = x_i - x0;
    dy    = y_i - Y_HALF;
    sub_x = inset_o ? XW'(dx << 1) : x_i;
    sub_y = inset_o ? YW'(dy << 1) : y_i;
    if (swap_i) begin
      top_x_o = x_i;   top_y_o = y_i;
      bot_x_o = sub_x; bot_y_o = sub_y;
    end else begin
      bot_x_o = x_i;   bot_y_o = y_i;
      top_x_o = sub_x; top_y_o = sub_y;
    end
  end
endmodule

// File: rtl/comp_weight.sv
module comp_weight import comp_pkg::*; (
  input  logic [1:0]      win_mode_i,
  input  logic [1:0]      blend_sel_i,
  input  logic            inset_i,
  output logic [WT_W-1:0] w_main_o,
  output logic [WT_W-1:0] w_sub_o
);
  logic [WT_W-1:0] sel;

  always_comb begin
    sel = WT_W'(blend_sel_i);
    if (win_e'(win_mode_i) == WIN_FULL) begin
      w_main_o = WT_W'(7) - sel;
      w_sub_o  = WT_W'(1) + sel;
    end else if (inset_i) begin
      w_main_o = WT_W'((WT_W'(3) - sel) << 1);
      w_sub_o  = WT_W'((WT_W'(1) + sel) << 1);
    end else begin
      w_main_o = WT_W'(8);
      w_sub_o  = '0;
    end
  end
endmodule

// File: rtl/comp_blend_ch.sv
module comp_blend_ch import comp_pkg::*; #(
  parameter int CH_W = 5,
  localparam int ACC_W = CH_W + WT_W
) (
  input  logic [CH_W-1:0] main_i,
  input  logic [CH_W-1:0] sub_i,
  input  logic [WT_W-1:0] w_main_i,
  input  logic [WT_W-1:0] w_sub_i,
  output logic [CH_W-1:0] mix_o
);
  logic [ACC_W-1:0] acc;

  always_comb begin
    acc   = ACC_W'(w_main_i) * ACC_W'(main_i) + ACC_W'(w_sub_i) * ACC_W'(sub_i);
    mix_o = CH_W'(acc >> WT_SHIFT);
  end
endmodule

// File: rtl/pic_compositor.sv
module pic_compositor import comp_pkg::*; #(
  parameter int H_PIX = 256,
  parameter int V_PIX = 192,
  parameter int CH_W  = 5,
  localparam int XW    = $clog2(H_PIX),
  localparam int YW    = $clog2(V_PIX),
  localparam int N_CH  = 3,
  localparam int PIX_W = N_CH * CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       win_mode_i,
  input  logic [1:0]       blend_sel_i,
  input  logic             swap_i,
  input  logic             in_valid_i,
  input  logic [XW-1:0]    x_i,
  input  logic [YW-1:0]    y_i,
  output logic [XW-1:0]    bot_x_o,
  output logic [YW-1:0]    bot_y_o,
  input  logic [PIX_W-1:0] bot_pix_i,
  output logic [XW-1:0]    top_x_o,
  output logic [YW-1:0]    top_y_o,
  input  logic [PIX_W-1:0] top_pix_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_pix_o
);
  logic            inset;
  logic [WT_W-1:0] wm, ws;

  comp_addr_gen #(.H_PIX(H_PIX), .V_PIX(V_PIX)) u_addr (
    .win_mode_i (win_mode_i),
    .swap_i     (swap_i),
    .x_i        (x_i),
    .y_i        (y_i),
    .bot_x_o    (bot_x_o),
    .bot_y_o    (bot_y_o),
    .top_x_o    (top_x_o),
    .top_y_o    (top_y_o),
    .inset_o    (inset)
  );

  comp_weight u_wt (
    .win_mode_i  (win_mode_i),
    .blend_sel_i (blend_sel_i),
    .inset_i     (inset),
    .w_main_o    (wm),
    .w_sub_o     (ws)
  );

  // stage 1: control travels alongside the source read
  logic            v1_q, swap1_q;
  logic [WT_W-1:0] wm1_q, ws1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      swap1_q <= 1'b0;
      wm1_q   <= '0;
      ws1_q   <= '0;
    end else begin
      v1_q    <= in_valid_i;
      swap1_q <= swap_i;
      wm1_q   <= wm;
      ws1_q   <= ws;
    end
  end

  logic [PIX_W-1:0] main_d, sub_d, mix_d;
  assign main_d = swap1_q ? top_pix_i : bot_pix_i;
  assign sub_d  = swap1_q ? bot_pix_i : top_pix_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    comp_blend_ch #(.CH_W(CH_W)) u_ch (
      .main_i   (main_d[c*CH_W +: CH_W]),
      .sub_i    (sub_d[c*CH_W +: CH_W]),
      .w_main_i (wm1_q),
      .w_sub_i  (ws1_q),
      .mix_o    (mix_d[c*CH_W +: CH_W])
    );
  end

  // stage 2: registered output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
    end else begin
      out_valid_o <= v1_q;
      out_pix_o   <= mix_d;
    end
  end
endmodule

// File: rtl/comp_chk.sv
module comp_chk #(
  parameter int H_PIX = 256,
  parameter int V_PIX = 192,
  parameter int XW    = 8,
  parameter int YW    = 8,
  parameter int PIX_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       win_mode_i,
  input logic [1:0]       blend_sel_i,
  input logic             swap_i,
  input logic             in_valid_i,
  input logic [XW-1:0]    x_i,
  input logic [YW-1:0]    y_i,
  input logic [XW-1:0]    bot_x_o,
  input logic [YW-1:0]    bot_y_o,
  input logic [PIX_W-1:0] bot_pix_i,
  input logic [XW-1:0]    top_x_o,
  input logic [YW-1:0]    top_y_o,
  input logic [PIX_W-1:0] top_pix_i,
  input logic             out_valid_o,
  input logic [PIX_W-1:0] out_pix_o
);
  localparam logic [XW-1:0] XH = XW'(H_PIX / 2);
  localparam logic [YW-1:0] YH = YW'(V_PIX / 2);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

  p_main_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && out_valid_o && $past(win_mode_i, 2) == 2'd0 && !$past(swap_i, 2))
    |-> (out_pix_o == $past(bot_pix_i)));

  p_swap_main_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && out_valid_o && $past(win_mode_i, 2) == 2'd0 && $past(swap_i, 2))
    |-> (out_pix_o == $past(top_pix_i)));

  p_inset_full_sub_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && out_valid_o && $past(win_mode_i, 2) == 2'd3 &&
     $past(blend_sel_i, 2) == 2'd3 && !$past(swap_i, 2) &&
     $past(x_i, 2) >= XH && $past(y_i, 2) >= YH)
    |-> (out_pix_o == $past(top_pix_i)));

  p_main_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (swap_i ? (top_x_o == x_i && top_y_o == y_i)
                           : (bot_x_o == x_i && bot_y_o == y_i)));

  p_inset_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && win_mode_i == 2'd2 && !swap_i && x_i < XH && y_i >= YH)
    |-> (top_x_o == XW'(x_i << 1) && top_y_o == YW'((y_i - YH) << 1)));
endmodule

bind pic_compositor comp_chk #(
  .H_PIX(H_PIX), .V_PIX(V_PIX), .XW(XW), .YW(YW), .PIX_W(PIX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .win_mode_i  (win_mode_i),
  .blend_sel_i (blend_sel_i),
  .swap_i      (swap_i),
  .in_valid_i  (in_valid_i),
  .x_i         (x_i),
  .y_i         (y_i),
  .bot_x_o     (bot_x_o),
  .bot_y_o     (bot_y_o),
  .bot_pix_i   (bot_pix_i),
  .top_x_o     (top_x_o),
  .top_y_o     (top_y_o),
  .top_pix_i   (top_pix_i),
  .out_valid_o (out_valid_o),
  .out_pix_o   (out_pix_o)
);

// File: tb/tb_pic_compositor.sv
module tb_pic_compositor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  win_mode_i = '0, blend_sel_i = '0;
  logic        swap_i = 1'b0, in_valid_i = 1'b0;
  logic [7:0]  x_i = '0, y_i = '0;
  logic [7:0]  bot_x_o, bot_y_o, top_x_o, top_y_o;
  logic [14:0] bot_pix_i, top_pix_i, out_pix_o;
  logic        out_valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pic_compositor dut (.*);

  // source picture content: distinct value per screen and address
  function automatic logic [14:0] pixf(input int scr, input int x, input int y);
    int v;
    v = x * 73 + y * 151 + scr * 9001 + (x ^ y) * 5 + x * y;
    return 15'(v);
  endfunction

  always_ff @(posedge clk_i) begin
    bot_pix_i <= pixf(0, int'(bot_x_o), int'(bot_y_o));
    top_pix_i <= pixf(1, int'(top_x_o), int'(top_y_o));
  end

  function automatic bit in_inset(input int m, input int x, input int y);
    return (m == 2 && x < 128 && y >= 96) || (m == 3 && x >= 128 && y >= 96);
  endfunction

  function automatic logic [14:0] exp_pix(input int m, input int s, input bit sw,
                                          input int x, input int y);
    logic [14:0] mp, sp, r;
    int sx, sy, a, b;
    bit ins;
    ins = in_inset(m, x, y);
    sx  = ins ? ((m == 2) ? 2 * x : 2 * (x - 128)) : x;
    sy  = ins ? 2 * (y - 96) : y;
    mp  = sw ? pixf(1, x, y) : pixf(0, x, y);
    sp  = sw ? pixf(0, sx, sy) : pixf(1, sx, sy);
    r   = mp;
    for (int c = 0; c < 3; c++) begin
      a = int'(mp[c*5 +: 5]);
      b = int'(sp[c*5 +: 5]);
      // R9: per-channel, truncated
      if (m == 1)   r[c*5 +: 5] = 5'(((7 - s) * a + (s + 1) * b) >> 3);
      else if (ins) r[c*5 +: 5] = 5'(((3 - s) * a + (s + 1) * b) >> 2);
    end
    return r;
  endfunction

  function automatic string tag_of(input int m, input bit sw, input int x, input int y);
    if (sw)               return "R8";
    if (m == 0)           return "R2";
    if (m == 1)           return "R3/R9";
    if (in_inset(m, x, y)) return "R6/R9";
    return (m == 2) ? "R4" : "R5";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit          p1_v = 0, p2_v = 0;
  logic [14:0] p1_p = '0, p2_p = '0;
  string       p1_t = "", p2_t = "";

  task automatic step(input bit v, input int m, input int s, input bit sw,
                      input int x, input int y);
    @(negedge clk_i);
    // R1: output belongs to the input two cycles back
    chk(out_valid_o == p2_v, "R1", int'(out_valid_o), int'(p2_v));
    if (p2_v) chk(out_pix_o == p2_p, p2_t, int'(out_pix_o), int'(p2_p));
    p2_v = p1_v; p2_p = p1_p; p2_t = p1_t;
    in_valid_i  = v;
    win_mode_i  = 2'(m);
    blend_sel_i = 2'(s);
    swap_i      = sw;
    x_i         = 8'(x);
    y_i         = 8'(y);
    p1_v = v;
    p1_p = exp_pix(m, s, sw, x, y);
    p1_t = tag_of(m, sw, x, y);
    #1;
    if (v) begin
      // R7: main read at (x,y); inset sub read at scaled coordinates
      if (sw) chk(top_x_o == 8'(x) && top_y_o == 8'(y), "R7", {top_x_o, top_y_o}, (x << 8) | y);
      else    chk(bot_x_o == 8'(x) && bot_y_o == 8'(y), "R7", {bot_x_o, bot_y_o}, (x << 8) | y);
      if (in_inset(m, x, y)) begin
        int ex, ey;
        ex = (m == 2) ? 2 * x : 2 * (x - 128);
        ey = 2 * (y - 96);
        if (sw) chk(bot_x_o == 8'(ex) && bot_y_o == 8'(ey), "R7", {bot_x_o, bot_y_o}, (ex << 8) | ey);
        else    chk(top_x_o == 8'(ex) && top_y_o == 8'(ey), "R7", {top_x_o, top_y_o}, (ex << 8) | ey);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int xs[4] = '{0, 127, 128, 255};
    int ys[4] = '{0, 95, 96, 191};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk(out_valid_o == 1'b0, "R10", int'(out_valid_o), 0);
    chk(out_pix_o == '0, "R10", int'(out_pix_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed: inset boundaries for every mode, select and swap (R4, R5, R6)
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int sw = 0; sw < 2; sw++)
          for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
              step(1'b1, m, s, sw[0], xs[i], ys[j]);

    // directed: valid gaps (R1)
    step(1'b0, 1, 0, 1'b0, 10, 10);
    step(1'b1, 1, 3, 1'b0, 11, 10);
    step(1'b0, 2, 0, 1'b0, 12, 100);
    step(1'b0, 3, 0, 1'b0, 200, 150);
    step(1'b1, 3, 3, 1'b1, 200, 150);

    // random mix of coordinates, controls and gaps
    for (int k = 0; k < 6000; k++)
      step(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % 4),
           1'($urandom % 2), int'($urandom % 256), int'($urandom % 192));

    step(1'b0, 0, 0, 1'b0, 0, 0);
    step(1'b0, 0, 0, 1'b0, 0, 0);
    step(1'b0, 0, 0, 1'b0, 0, 0);
    finish_run();
  end
endmodule